// File: doc/BRIEF.md
# NAND Bus Cycle Timing Generator

This block drives the control and data pins of an 8-bit NAND flash device for one single-byte access at a time. There are four kinds of access: a command write, an address write, a data write and a data read. A 32-bit timing word gives each direction (read, write) its own setup, strobe-width and hold counts, and its own wait before the ready/busy pin is sampled. The block captures the timing word when it accepts a request, so software may rewrite the word while an access is in flight.

An access runs through four steps. The block drives control and data for the setup count. It then pulls the write or read strobe low for the width count, and keeps control valid for the hold count. After an optional ready-sample wait, it watches the synchronised ready/busy pin until the device reports ready. It then raises `done_o` for one clock. For a read, the byte is captured on the last clock of the strobe-low phase and is presented on `rdata_o`. A requester presents `req_valid_i` and must hold it until the block takes the request; `req_ready_o` is high only while the generator is idle.

Top module: `nand_cycle_gen`

## Requirements
- R1: Each 4-bit setup, width and hold field gives field value + 1 clocks. Read cycles take setup from bits [3:0], hold from [7:4], width from [11:8] and ready wait from [15:12]. Write cycles take setup from [19:16], hold from [23:20], width from [27:24] and ready wait from [31:28]. The strobe first goes low exactly setup + 1 clocks after acceptance.
- R2: A write access (kind 2'b00, 2'b01 or 2'b10) drives `nand_dq_o` with the request byte and asserts `nand_dq_oe_o` for setup+width+hold+3 clocks. `nand_we_n_o` is low for exactly width + 1 of those clocks, and `nand_re_n_o` stays high.
- R3: A read access (kind 2'b11) holds `nand_re_n_o` low for width + 1 clocks and keeps `nand_we_n_o` high. It returns on `rdata_o` the value `nand_dq_i` had in the last clock before `nand_re_n_o` rises. `rdata_o` holds that value until the next read completes.
- R4: Kind 2'b00 (command) asserts `nand_cle_o`, and kind 2'b01 (address) asserts `nand_ale_o`. Each stays high for setup+width+hold+3 clocks. Data accesses assert neither, and CLE and ALE are never high together.
- R5: A ready wait field n adds 2*n clocks after the hold phase before the ready pin is considered. When the device is busy (`nand_rb_n_i` low), `done_o` follows exactly 3 clocks after the pin returns high.
- R6: `req_ready_o` is low from acceptance until `done_o`. A request held valid during that time is not taken and does not disturb the current access.
- R7: `done_o` is a single-clock pulse. With the device ready throughout, it rises setup+width+hold+2*n+4 clocks after the accepting edge.
- R8: `nand_ce_n_o` is low while `force_ce_i` is high, whatever the generator state. With `force_ce_i` low, it is low only during the setup, strobe and hold phases of an access.
- R9: The timing word is sampled at acceptance; changing `timing_i` during an access has no effect on that access.
- R10: After reset the block is idle with `req_ready_o` high, both strobes high, CLE, ALE, `nand_dq_oe_o` and `done_o` low, and `rdata_o` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| timing_i | input | 32 | Phase timing word, sampled at acceptance |
| force_ce_i | input | 1 | Hold chip enable asserted |
| req_valid_i | input | 1 | Access request |
| req_kind_i | input | 2 | 00 command, 01 address, 10 data write, 11 data read |
| req_wdata_i | input | 8 | Byte for write kinds |
| req_ready_o | output | 1 | Generator idle, request accepted this clock if valid |
| done_o | output | 1 | One-clock pulse at access end |
| rdata_o | output | 8 | Last byte read |
| nand_ce_n_o | output | 1 | Chip enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_n_o | output | 1 | Write strobe, active low |
| nand_re_n_o | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data bus out |
| nand_dq_oe_o | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus in |
| nand_rb_n_i | input | 1 | Device ready (high) / busy (low) |

## Verification
A phase counter that stops one value early or late changes the strobe's low count or its start clock within that same access. It also shifts `done_o` by a clock or more, so every timing fault appears before the access ends. A wrong field choice, such as read timing used for a write, moves all of these counts at once. A capture taken in the wrong clock shows up in `rdata_o` at the next `done_o`, because the bench changes the data bus every clock. A state that fails to leave the ready-check phase, or leaves it too soon, appears as a `done_o` latency that does not match the release of the ready pin.

// File: rtl/nand_cyc_pkg.sv
package nand_cyc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_PULSE,
        PH_HOLD,
        PH_WAIT,
        PH_CHECK
    } phase_t;

    typedef enum logic [1:0] {
        K_CMD  = 2'b00,
        K_ADDR = 2'b01,
        K_WR   = 2'b10,
        K_RD   = 2'b11
    } kind_t;

    localparam int unsigned FIELDS_PER_DIR = 4;
    localparam int unsigned NUM_DIRS       = 2;

endpackage

// File: rtl/nand_timing_select.sv
module nand_timing_select #(
    parameter int unsigned FIELD_W = 4,
    localparam int unsigned DIR_W  = FIELD_W * nand_cyc_pkg::FIELDS_PER_DIR,
    localparam int unsigned TIM_W  = DIR_W * nand_cyc_pkg::NUM_DIRS
) (
    input  logic [TIM_W-1:0]   timing_i,
    input  logic               is_read_i,
    output logic [FIELD_W-1:0] setup_o,
    output logic [FIELD_W-1:0] hold_o,
    output logic [FIELD_W-1:0] width_o,
    output logic [FIELD_W-1:0] wait_o
);
    logic [FIELD_W-1:0] lane_setup [nand_cyc_pkg::NUM_DIRS];
    logic [FIELD_W-1:0] lane_hold  [nand_cyc_pkg::NUM_DIRS];
    logic [FIELD_W-1:0] lane_width [nand_cyc_pkg::NUM_DIRS];
    logic [FIELD_W-1:0] lane_wait  [nand_cyc_pkg::NUM_DIRS];

    // lane 0 carries read timing, lane 1 write timing
    for (genvar g = 0; g < int'(nand_cyc_pkg::NUM_DIRS); g++) begin : g_lane
        localparam int unsigned BASE = g * DIR_W;
        assign lane_setup[g] = timing_i[BASE + 0*FIELD_W +: FIELD_W];
        assign lane_hold[g]  = timing_i[BASE + 1*FIELD_W +: FIELD_W];
        assign lane_width[g] = timing_i[BASE + 2*FIELD_W +: FIELD_W];
        assign lane_wait[g]  = timing_i[BASE + 3*FIELD_W +: FIELD_W];
    end

    always_comb begin
        if (is_read_i) begin
            setup_o = lane_setup[0];
            hold_o  = lane_hold[0];
            width_o = lane_width[0];
            wait_o  = lane_wait[0];
        end else begin
            setup_o = lane_setup[1];
            hold_o  = lane_hold[1];
            width_o = lane_width[1];
            wait_o  = lane_wait[1];
        end
    end
endmodule

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < int'(STAGES); i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/nand_cycle_fsm.sv
module nand_cycle_fsm
    import nand_cyc_pkg::*;
#(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned FIELD_W = 4,
    localparam int unsigned TIM_W  = FIELD_W * FIELDS_PER_DIR * NUM_DIRS,
    localparam int unsigned CNT_W  = FIELD_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid_i,
    input  logic [1:0]         req_kind_i,
    input  logic [DATA_W-1:0]  req_wdata_i,
    input  logic [TIM_W-1:0]   timing_i,
    input  logic               force_ce_i,
    input  logic [FIELD_W-1:0] setup_i,
    input  logic [FIELD_W-1:0] hold_i,
    input  logic [FIELD_W-1:0] width_i,
    input  logic [FIELD_W-1:0] wait_i,
    input  logic               rb_ready_i,
    input  logic [DATA_W-1:0]  dq_i,
    output logic [TIM_W-1:0]   timing_q_o,
    output logic               is_read_o,
    output logic               req_ready_o,
    output logic               done_o,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               ce_n_o,
    output logic               cle_o,
    output logic               ale_o,
    output logic               we_n_o,
    output logic               re_n_o,
    output logic [DATA_W-1:0]  dq_o,
    output logic               dq_oe_o
);
    typedef struct packed {
        phase_t            phase;
        logic [CNT_W-1:0]  cnt;
        kind_t             kind;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic [TIM_W-1:0]  timing;
        logic              done;
    } state_t;

    state_t st_d, st_q;

    logic [CNT_W-1:0] setup_lim, hold_lim, width_lim, wait_lim;
    logic             active;

    assign setup_lim = CNT_W'(setup_i);
    assign hold_lim  = CNT_W'(hold_i);
    assign width_lim = CNT_W'(width_i);
    assign wait_lim  = {wait_i, 1'b0} - CNT_W'(1);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (req_valid_i) begin
                    st_d.phase  = PH_SETUP;
                    st_d.cnt    = '0;
                    st_d.kind   = kind_t'(req_kind_i);
                    st_d.wdata  = req_wdata_i;
                    st_d.timing = timing_i;
                end
            end
            PH_SETUP: begin
                if (st_q.cnt == setup_lim) begin
                    st_d.phase = PH_PULSE;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            PH_PULSE: begin
                if (st_q.cnt == width_lim) begin
                    st_d.phase = PH_HOLD;
                    st_d.cnt   = '0;
                    if (st_q.kind == K_RD) st_d.rdata = dq_i;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            PH_HOLD: begin
                if (st_q.cnt == hold_lim) begin
                    st_d.phase = (wait_i == '0) ? PH_CHECK : PH_WAIT;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            PH_WAIT: begin
                if (st_q.cnt == wait_lim) begin
                    st_d.phase = PH_CHECK;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            PH_CHECK: begin
                if (rb_ready_i) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, kind: K_CMD, wdata: '0,
                      rdata: '0, timing: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign active      = (st_q.phase == PH_SETUP) || (st_q.phase == PH_PULSE)
                      || (st_q.phase == PH_HOLD);
    assign timing_q_o  = st_q.timing;
    assign is_read_o   = (st_q.kind == K_RD);
    assign req_ready_o = (st_q.phase == PH_IDLE);
    assign done_o      = st_q.done;
    assign rdata_o     = st_q.rdata;
    assign ce_n_o      = !(force_ce_i || active);
    assign cle_o       = active && (st_q.kind == K_CMD);
    assign ale_o       = active && (st_q.kind == K_ADDR);
    assign we_n_o      = !((st_q.phase == PH_PULSE) && (st_q.kind != K_RD));
    assign re_n_o      = !((st_q.phase == PH_PULSE) && (st_q.kind == K_RD));
    assign dq_o        = st_q.wdata;
    assign dq_oe_o     = active && (st_q.kind != K_RD);
endmodule

// File: rtl/nand_cycle_gen.sv
module nand_cycle_gen #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned FIELD_W     = 4,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned TIM_W = FIELD_W * nand_cyc_pkg::FIELDS_PER_DIR
                                  * nand_cyc_pkg::NUM_DIRS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIM_W-1:0]  timing_i,
    input  logic              force_ce_i,
    input  logic              req_valid_i,
    input  logic [1:0]        req_kind_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              req_ready_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              nand_ce_n_o,
    output logic              nand_cle_o,
    output logic              nand_ale_o,
    output logic              nand_we_n_o,
    output logic              nand_re_n_o,
    output logic [DATA_W-1:0] nand_dq_o,
    output logic              nand_dq_oe_o,
    input  logic [DATA_W-1:0] nand_dq_i,
    input  logic              nand_rb_n_i
);
    logic [TIM_W-1:0]   timing_q;
    logic               is_read;
    logic [FIELD_W-1:0] f_setup, f_hold, f_width, f_wait;
    logic               rb_ready;

    nand_timing_select #(.FIELD_W(FIELD_W)) u_sel (
        .timing_i (timing_q),
        .is_read_i(is_read),
        .setup_o  (f_setup),
        .hold_o   (f_hold),
        .width_o  (f_width),
        .wait_o   (f_wait)
    );

    nand_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(nand_rb_n_i),
        .sync_o (rb_ready)
    );

    nand_cycle_fsm #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid_i(req_valid_i),
        .req_kind_i (req_kind_i),
        .req_wdata_i(req_wdata_i),
        .timing_i   (timing_i),
        .force_ce_i (force_ce_i),
        .setup_i    (f_setup),
        .hold_i     (f_hold),
        .width_i    (f_width),
        .wait_i     (f_wait),
        .rb_ready_i (rb_ready),
        .dq_i       (nand_dq_i),
        .timing_q_o (timing_q),
        .is_read_o  (is_read),
        .req_ready_o(req_ready_o),
        .done_o     (done_o),
        .rdata_o    (rdata_o),
        .ce_n_o     (nand_ce_n_o),
        .cle_o      (nand_cle_o),
        .ale_o      (nand_ale_o),
        .we_n_o     (nand_we_n_o),
        .re_n_o     (nand_re_n_o),
        .dq_o       (nand_dq_o),
        .dq_oe_o    (nand_dq_oe_o)
    );
endmodule

// File: rtl/nand_cycle_gen_checker.sv
module nand_cycle_gen_checker #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              force_ce_i,
    input logic              req_ready_o,
    input logic              done_o,
    input logic [DATA_W-1:0] rdata_o,
    input logic              nand_ce_n_o,
    input logic              nand_cle_o,
    input logic              nand_ale_o,
    input logic              nand_we_n_o,
    input logic              nand_re_n_o,
    input logic              nand_dq_oe_o
);
    // R2 R3: only one strobe is ever low
    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n_o && !nand_re_n_o));

    // R2: write strobe low only while the bus is driven
    a_r2_we_with_data: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n_o |-> nand_dq_oe_o);

    // R4: CLE and ALE exclusive
    a_r4_cle_ale_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle_o && nand_ale_o));

    // R6: idle generator drives no access
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> (nand_we_n_o && nand_re_n_o && !nand_cle_o
                         && !nand_ale_o && !nand_dq_oe_o));

    // R7: done is a single-clock pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3: read data held while idle
    a_r3_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready_o && $past(req_ready_o) && !done_o) |-> $stable(rdata_o));

    // R8: forced chip enable
    a_r8_force_ce: assert property (@(posedge clk) disable iff (!rst_n)
        force_ce_i |-> !nand_ce_n_o);

    // R8: control lines only with chip enabled
    a_r8_ce_covers: assert property (@(posedge clk) disable iff (!rst_n)
        (nand_cle_o || nand_ale_o || !nand_we_n_o || !nand_re_n_o) |-> !nand_ce_n_o);
endmodule

bind nand_cycle_gen nand_cycle_gen_checker #(.DATA_W(DATA_W)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .force_ce_i  (force_ce_i),
    .req_ready_o (req_ready_o),
    .done_o      (done_o),
    .rdata_o     (rdata_o),
    .nand_ce_n_o (nand_ce_n_o),
    .nand_cle_o  (nand_cle_o),
    .nand_ale_o  (nand_ale_o),
    .nand_we_n_o (nand_we_n_o),
    .nand_re_n_o (nand_re_n_o),
    .nand_dq_oe_o(nand_dq_oe_o)
);

// File: tb/nand_cycle_gen_bench.sv
`timescale 1ns/1ps
module nand_cycle_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] timing_i = '0;
    logic        force_ce_i = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [1:0]  req_kind_i = '0;
    logic [7:0]  req_wdata_i = '0;
    logic        req_ready_o, done_o;
    logic [7:0]  rdata_o;
    logic        nand_ce_n_o, nand_cle_o, nand_ale_o, nand_we_n_o, nand_re_n_o;
    logic [7:0]  nand_dq_o;
    logic        nand_dq_oe_o;
    logic [7:0]  nand_dq_i = '0;
    logic        nand_rb_n_i = 1'b1;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    nand_cycle_gen u_nand_cycle_gen (
        .clk(clk), .rst_n(rst_n), .timing_i(timing_i), .force_ce_i(force_ce_i),
        .req_valid_i(req_valid_i), .req_kind_i(req_kind_i), .req_wdata_i(req_wdata_i),
        .req_ready_o(req_ready_o), .done_o(done_o), .rdata_o(rdata_o),
        .nand_ce_n_o(nand_ce_n_o), .nand_cle_o(nand_cle_o), .nand_ale_o(nand_ale_o),
        .nand_we_n_o(nand_we_n_o), .nand_re_n_o(nand_re_n_o), .nand_dq_o(nand_dq_o),
        .nand_dq_oe_o(nand_dq_oe_o), .nand_dq_i(nand_dq_i), .nand_rb_n_i(nand_rb_n_i)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] bus_val(input int k);
        return 8'(k * 37 + 11);
    endfunction

    function automatic int fld(input logic [31:0] t, input int pos);
        return int'(t[pos +: 4]);
    endfunction

    logic [7:0] last_rd = 8'h00;

    task automatic do_access(input logic [1:0] kind, input logic [7:0] wd,
                             input logic [31:0] tr, input int busy_k);
        int base, s, w, h, n, lat, k;
        int we_cnt, re_cnt, cle_cnt, ale_cnt, oe_cnt, ce_cnt, rdy_busy, dq_bad;
        int first_low, exp_lat;
        bit rd;
        rd   = (kind == 2'b11);
        base = rd ? 0 : 16;
        s = fld(tr, base); h = fld(tr, base + 4);
        w = fld(tr, base + 8); n = fld(tr, base + 12);
        exp_lat = s + w + h + 2*n + 4;
        if (busy_k > 0) exp_lat = busy_k + 3;
        we_cnt = 0; re_cnt = 0; cle_cnt = 0; ale_cnt = 0; oe_cnt = 0; ce_cnt = 0;
        rdy_busy = 0; dq_bad = 0; first_low = -1; lat = -1;

        @(negedge clk);
        chk(req_ready_o == 1'b1, "R6 ready before request", int'(req_ready_o), 1);
        req_valid_i = 1'b1; req_kind_i = kind; req_wdata_i = wd; timing_i = tr;
        if (busy_k > 0) nand_rb_n_i = 1'b0;
        @(posedge clk);
        #1 timing_i = $urandom;          // R9: ignored by the running access
        k = 0;
        forever begin
            @(negedge clk);
            if (done_o) begin lat = k; break; end
            if (!nand_we_n_o) begin we_cnt++; if (first_low < 0) first_low = k; end
            if (!nand_re_n_o) begin re_cnt++; if (first_low < 0) first_low = k; end
            if (nand_cle_o) cle_cnt++;
            if (nand_ale_o) ale_cnt++;
            if (nand_dq_oe_o) begin oe_cnt++; if (nand_dq_o != wd) dq_bad++; end
            if (!nand_ce_n_o) ce_cnt++;
            if (req_ready_o) rdy_busy++;
            nand_dq_i = bus_val(k);
            if (busy_k > 0 && k == busy_k) nand_rb_n_i = 1'b1;
            if (k > 3000) break;
            @(posedge clk);
            k++;
        end
        req_valid_i = 1'b0;

        chk(lat == exp_lat, busy_k > 0 ? "R5 done after ready release" : "R7 done latency",
            lat, exp_lat);
        chk(first_low == s + 1, "R1 strobe start", first_low, s + 1);
        chk(rdy_busy == 0, "R6 ready low while busy", rdy_busy, 0);
        chk(ce_cnt == s + w + h + 3, "R8 CE active window", ce_cnt, s + w + h + 3);
        chk(cle_cnt == ((kind == 2'b00) ? s + w + h + 3 : 0), "R4 CLE window",
            cle_cnt, (kind == 2'b00) ? s + w + h + 3 : 0);
        chk(ale_cnt == ((kind == 2'b01) ? s + w + h + 3 : 0), "R4 ALE window",
            ale_cnt, (kind == 2'b01) ? s + w + h + 3 : 0);
        if (rd) begin
            last_rd = bus_val(s + w + 1);
            chk(re_cnt == w + 1, "R3 RE width", re_cnt, w + 1);
            chk(we_cnt == 0, "R3 WE idle on read", we_cnt, 0);
            chk(oe_cnt == 0, "R3 bus not driven on read", oe_cnt, 0);
        end else begin
            chk(we_cnt == w + 1, "R2 WE width", we_cnt, w + 1);
            chk(re_cnt == 0, "R2 RE idle on write", re_cnt, 0);
            chk(oe_cnt == s + w + h + 3 && dq_bad == 0, "R2 data window",
                oe_cnt - dq_bad, s + w + h + 3);
        end
        chk(rdata_o == last_rd, "R3 read byte", int'(rdata_o), int'(last_rd));
        @(negedge clk);
        chk(done_o == 1'b0, "R7 done single pulse", int'(done_o), 0);
        chk(req_ready_o == 1'b1, "R6 ready after done", int'(req_ready_o), 1);
    endtask

    initial begin
        #(20 * 190000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk(req_ready_o == 1 && nand_we_n_o == 1 && nand_re_n_o == 1, "R10 idle strobes",
            int'({req_ready_o, nand_we_n_o, nand_re_n_o}), 7);
        chk(!nand_cle_o && !nand_ale_o && !nand_dq_oe_o && !done_o && rdata_o == 0,
            "R10 idle controls", int'({nand_cle_o, nand_ale_o, nand_dq_oe_o, done_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(nand_ce_n_o == 1'b1, "R8 CE high idle", int'(nand_ce_n_o), 1);
        force_ce_i = 1'b1;
        #1;
        chk(nand_ce_n_o == 1'b0, "R8 forced CE", int'(nand_ce_n_o), 0);
        @(negedge clk);
        force_ce_i = 1'b0;
        #1;
        chk(nand_ce_n_o == 1'b1, "R8 CE released", int'(nand_ce_n_o), 1);

        // directed corners: all fields zero and all fields maximal (R1)
        do_access(2'b00, 8'hA5, 32'h0000_0000, 0);
        do_access(2'b11, 8'h00, 32'h0000_0000, 0);
        do_access(2'b10, 8'h3C, 32'hFFFF_FFFF, 0);
        do_access(2'b11, 8'h00, 32'hFFFF_FFFF, 0);
        // read vs write field separation (R1)
        do_access(2'b01, 8'h5A, 32'h0000_F3F2, 0);
        do_access(2'b11, 8'h00, 32'h2F3F_0051, 0);
        // busy device (R5)
        do_access(2'b00, 8'h70, 32'h1111_1111, 40);
        do_access(2'b11, 8'h00, 32'h0123_0321, 60);

        for (int i = 0; i < 60; i++) begin
            do_access(2'($urandom), 8'($urandom), $urandom, 0);
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule